// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers every interrupt-style request a processor core can see and, each clock cycle, chooses the one the core should service next. The inputs are three reset-class sources, two trap-class sources, two active-low request pins and a parameterized bank of peripheral request lines. The core's two condition-code mask bits come in directly. One mask guards only the high-rank pin. The other guards the general pin and every peripheral. A small register port holds one local enable bit for each peripheral.

When several qualified requests are present together, the lowest rank wins. The block registers the winner's rank and the address of its 16-bit vector word, along with a valid strobe. The core uses these to fetch the handler address from a reserved page at the top of the address space. The block does not latch requests: a blocked request simply stays asserted at its input and competes again as soon as its mask clears. Saving processor state and reading the vector word belong to the core.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request present, `req_valid` is 0 and `req_src` and `req_vector` are 0. Whenever `req_valid` is 0, `req_src` and `req_vector` are 0. Reset clears every local enable bit, so every enable word reads back 0.
- R2: Ranks are fixed as follows: 0 external reset, 1 clock-monitor failure, 2 watchdog timeout, 3 illegal opcode trap, 4 software trap, 5 `xirq_n` pin, 6 `irq_n` pin, and 7+k for `periph_req[k]`. When several qualified requests are present, the lowest rank is reported.
- R3: Ranks 0 to 2 are never blocked by `ccr_x`, by `ccr_i` or by any local enable.
- R4: Ranks 3 and 4 are never blocked by `ccr_x`, by `ccr_i` or by any local enable.
- R5: `xirq_n` held low requests rank 5 when `ccr_x` is 0. It is blocked when `ccr_x` is 1, and `ccr_i` has no effect on it.
- R6: `irq_n` held low requests rank 6 when `ccr_i` is 0 and is blocked when `ccr_i` is 1.
- R7: `periph_req[k]` qualifies only while local enable bit k is 1 and `ccr_i` is 0.
- R8: While `req_valid` is 1, `req_vector` equals 0xFFFE minus twice `req_src`. Every vector therefore lies in 0xFF00 to 0xFFFF.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising edge. `req_valid` falls in the cycle after the last qualified request is removed or masked.
- R10: A blocked request that stays asserted is reported in the cycle after its mask clears. No new edge on the request is needed.
- R11: A write with `cfg_we`=1 to word address a loads enable bits a*CFG_DW upward from `cfg_wdata`. `cfg_rdata` returns the addressed word combinationally. Bits beyond the last peripheral read 0. Writes to addresses past the last word change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_ext_req | input | 1 | External reset request, rank 0 |
| clkmon_fail | input | 1 | Clock-monitor failure, rank 1 |
| wdog_tmo | input | 1 | Watchdog timeout, rank 2 |
| illegal_op | input | 1 | Illegal opcode trap, rank 3 |
| swi_req | input | 1 | Software trap, rank 4 |
| xirq_n | input | 1 | Active-low high-rank pin, rank 5 |
| irq_n | input | 1 | Active-low general pin, rank 6 |
| periph_req | input | NUM_PERIPH | Peripheral requests, bit k is rank 7+k |
| ccr_x | input | 1 | Mask for `xirq_n` (1 blocks) |
| ccr_i | input | 1 | Mask for `irq_n` and peripherals (1 blocks) |
| cfg_we | input | 1 | Enable-word write strobe |
| cfg_addr | input | CFG_AW | Enable-word address |
| cfg_wdata | input | CFG_DW | Enable-word write data |
| cfg_rdata | output | CFG_DW | Addressed enable word |
| req_valid | output | 1 | A qualified request is being reported |
| req_src | output | SRC_W | Rank of the winning source |
| req_vector | output | 16 | Address of the winner's vector word |

## Verification
The bench sets every mask to 1 with many sources asserted. A design that let a mask reach the reset or trap classes would then report nothing, or the wrong rank. It also drives `xirq_n` low with only `ccr_i` set, and `irq_n` low with only `ccr_x` set. These two cases catch masks wired to the wrong pin. Peripherals are driven with bits that have no enable and with the top-ranked peripheral, which exposes a design that skips the local enable or computes the vector offset wrongly. Directed cycles catch an added pipeline stage or a combinational path: an input change must not show before the edge and must show right after it. Clearing a mask under a held request catches a design that needs a fresh edge, and a write past the last enable word catches address aliasing.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      CLS_RESET,
      CLS_TRAP,
      CLS_MASKABLE
   } src_class_e;

   localparam int unsigned RANK_EXT_RST  = 0;
   localparam int unsigned RANK_CLK_MON  = 1;
   localparam int unsigned RANK_WDOG     = 2;
   localparam int unsigned RANK_BAD_OP   = 3;
   localparam int unsigned RANK_SW_TRAP  = 4;
   localparam int unsigned RANK_XPIN     = 5;
   localparam int unsigned RANK_GPIN     = 6;
   localparam int unsigned FIXED_SRCS    = 7;

   localparam logic [15:0] PAGE_BASE     = 16'hFF00;

   function automatic src_class_e class_of(input int unsigned rank);
      if (rank <= RANK_WDOG)
         return CLS_RESET;
      else if (rank <= RANK_SW_TRAP)
         return CLS_TRAP;
      return CLS_MASKABLE;
   endfunction

   // each rank owns one 16-bit word, counting down from the top
   function automatic logic [15:0] vector_of(input logic [15:0] top,
                                             input logic [7:0]  rank);
      return top - {7'd0, rank, 1'b0};
   endfunction

endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs #(
   parameter int unsigned NUM_PERIPH = 12,
   parameter int unsigned CFG_DW     = 8,
   parameter int unsigned CFG_AW     = 2,
   parameter bit          EN_RESET   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [CFG_DW-1:0]     cfg_wdata,
   output logic [CFG_DW-1:0]     cfg_rdata,
   output logic [NUM_PERIPH-1:0] periph_en
);

   localparam int unsigned WORDS = (NUM_PERIPH + CFG_DW - 1) / CFG_DW;
   localparam int unsigned PADW  = WORDS * CFG_DW;

   if (WORDS > (1 << CFG_AW)) begin : g_bad_aw
      $error("irq_en_regs: CFG_AW too narrow for the enable words");
   end

   logic [PADW-1:0] bank;

   for (genvar b = 0; b < PADW; b++) begin : g_bit
      if (b < NUM_PERIPH) begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= EN_RESET;
            else if (cfg_we && (cfg_addr == CFG_AW'(b / CFG_DW)))
               q <= cfg_wdata[b % CFG_DW];
         end
         assign bank[b] = q;
      end else begin : g_pad
         assign bank[b] = 1'b0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (cfg_addr == CFG_AW'(w))
            cfg_rdata = bank[w*CFG_DW +: CFG_DW];
      end
   end

   assign periph_en = bank[NUM_PERIPH-1:0];

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 12,
   localparam int unsigned NSRC      = FIXED_SRCS + NUM_PERIPH
) (
   input  logic [NSRC-1:0]       raw_req,
   input  logic [NUM_PERIPH-1:0] periph_en,
   input  logic                  ccr_x,
   input  logic                  ccr_i,
   output logic [NSRC-1:0]       qual_req
);

   for (genvar r = 0; r < NSRC; r++) begin : g_src
      localparam src_class_e CLS = class_of(r);
      if (CLS != CLS_MASKABLE) begin : g_unmaskable
         assign qual_req[r] = raw_req[r];
      end else if (r == RANK_XPIN) begin : g_xpin
         assign qual_req[r] = raw_req[r] & ~ccr_x;
      end else if (r == RANK_GPIN) begin : g_gpin
         assign qual_req[r] = raw_req[r] & ~ccr_i;
      end else begin : g_periph
         assign qual_req[r] = raw_req[r] & periph_en[r - FIXED_SRCS] & ~ccr_i;
      end
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N  = 19,
   parameter int unsigned IW = 5
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   // scan from the bottom rank upward so the lowest index overwrites last
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 12,
   parameter int unsigned CFG_DW     = 8,
   parameter int unsigned CFG_AW     = 2,
   parameter logic [15:0] VEC_TOP    = 16'hFFFE,
   parameter bit          EN_RESET   = 1'b0,
   localparam int unsigned NSRC      = FIXED_SRCS + NUM_PERIPH,
   localparam int unsigned SRC_W     = $clog2(NSRC)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rst_ext_req,
   input  logic                  clkmon_fail,
   input  logic                  wdog_tmo,
   input  logic                  illegal_op,
   input  logic                  swi_req,
   input  logic                  xirq_n,
   input  logic                  irq_n,
   input  logic [NUM_PERIPH-1:0] periph_req,
   input  logic                  ccr_x,
   input  logic                  ccr_i,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [CFG_DW-1:0]     cfg_wdata,
   output logic [CFG_DW-1:0]     cfg_rdata,
   output logic                  req_valid,
   output logic [SRC_W-1:0]      req_src,
   output logic [15:0]           req_vector
);

   if (NUM_PERIPH < 1 || NSRC > 128) begin : g_bad_count
      $error("irq_arbiter: source count outside 8..128");
   end
   if (VEC_TOP[0] != 1'b0 ||
       (int'(VEC_TOP) - 2 * (int'(NSRC) - 1)) < int'(PAGE_BASE)) begin : g_bad_top
      $error("irq_arbiter: vectors do not fit the reserved page");
   end

   logic [NSRC-1:0]       raw_req;
   logic [NSRC-1:0]       qual_req;
   logic [NUM_PERIPH-1:0] periph_en;
   logic                  win_any;
   logic [SRC_W-1:0]      win_idx;

   assign raw_req = {periph_req, ~irq_n, ~xirq_n,
                     swi_req, illegal_op,
                     wdog_tmo, clkmon_fail, rst_ext_req};

   irq_en_regs #(
      .NUM_PERIPH (NUM_PERIPH),
      .CFG_DW     (CFG_DW),
      .CFG_AW     (CFG_AW),
      .EN_RESET   (EN_RESET)
   ) u_en_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .periph_en (periph_en)
   );

   irq_qualify #(
      .NUM_PERIPH (NUM_PERIPH)
   ) u_qualify (
      .raw_req   (raw_req),
      .periph_en (periph_en),
      .ccr_x     (ccr_x),
      .ccr_i     (ccr_i),
      .qual_req  (qual_req)
   );

   irq_prio_pick #(
      .N  (NSRC),
      .IW (SRC_W)
   ) u_pick (
      .req (qual_req),
      .any (win_any),
      .idx (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid  <= 1'b0;
         req_src    <= '0;
         req_vector <= '0;
      end else if (win_any) begin
         req_valid  <= 1'b1;
         req_src    <= win_idx;
         req_vector <= vector_of(VEC_TOP, 8'(win_idx));
      end else begin
         req_valid  <= 1'b0;
         req_src    <= '0;
         req_vector <= '0;
      end
   end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
   parameter int unsigned NUM_PERIPH = 12,
   parameter int unsigned SRC_W      = 5,
   parameter logic [15:0] VEC_TOP    = 16'hFFFE
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rst_ext_req,
   input logic                  clkmon_fail,
   input logic                  wdog_tmo,
   input logic                  illegal_op,
   input logic                  swi_req,
   input logic                  xirq_n,
   input logic                  irq_n,
   input logic [NUM_PERIPH-1:0] periph_req,
   input logic                  ccr_x,
   input logic                  ccr_i,
   input logic                  req_valid,
   input logic [SRC_W-1:0]      req_src,
   input logic [15:0]           req_vector
);

   logic any_raw;
   logic hi_class;

   assign hi_class = rst_ext_req | clkmon_fail | wdog_tmo | illegal_op | swi_req;
   assign any_raw  = hi_class | ~xirq_n | ~irq_n | (|periph_req);

   // R1
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (req_src == '0 && req_vector == 16'h0000));

   // R8
   vector_matches_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_vector == VEC_TOP - 16'({req_src, 1'b0})));

   // R3
   ext_reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ext_req |=> (req_valid && req_src == '0));

   // R4
   trap_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_op && !rst_ext_req && !clkmon_fail && !wdog_tmo)
      |=> (req_valid && req_src == SRC_W'(3)));

   // R5
   xpin_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xirq_n && !ccr_x) |=> (req_valid && req_src <= SRC_W'(5)));

   // R6
   imask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_i && (ccr_x || xirq_n) && !hi_class) |=> !req_valid);

   // R9
   no_request_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_raw |=> !req_valid);

endmodule

bind irq_arbiter irq_arbiter_chk #(
   .NUM_PERIPH (NUM_PERIPH),
   .SRC_W      (SRC_W),
   .VEC_TOP    (VEC_TOP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rst_ext_req (rst_ext_req),
   .clkmon_fail (clkmon_fail),
   .wdog_tmo    (wdog_tmo),
   .illegal_op  (illegal_op),
   .swi_req     (swi_req),
   .xirq_n      (xirq_n),
   .irq_n       (irq_n),
   .periph_req  (periph_req),
   .ccr_x       (ccr_x),
   .ccr_i       (ccr_i),
   .req_valid   (req_valid),
   .req_src     (req_src),
   .req_vector  (req_vector)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;

   localparam int NP    = 12;
   localparam int DW    = 8;
   localparam int AW    = 2;
   localparam int SW    = 5;
   localparam int NVEC  = 18;

   typedef struct packed {
      logic          rst, cm, wd, ill, swi, xn, gn, cx, ci;
      logic [NP-1:0] pr;
      logic          ev;
      logic [SW-1:0] es;
      logic [3:0]    rq;
   } vec_t;

   // enables in use for the table: 12'hCA5 (peripherals 0,2,5,7,10,11)
   localparam vec_t TBL [NVEC] = '{
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000,1'b0,5'd0, 4'd9}, // R9 idle
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,12'h000,1'b1,5'd0, 4'd3}, // R3 masks set
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,12'hFFF,1'b1,5'd0, 4'd2}, // R2 all on
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,12'h000,1'b1,5'd1, 4'd3}, // R3
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,12'h000,1'b1,5'd2, 4'd3}, // R3
      '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,12'h000,1'b1,5'd3, 4'd4}, // R4
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,12'hFFF,1'b1,5'd4, 4'd4}, // R4
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,12'h000,1'b1,5'd5, 4'd5}, // R5 I ignored
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'h000,1'b0,5'd0, 4'd5}, // R5 X blocks
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,12'h000,1'b1,5'd6, 4'd6}, // R6
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,12'hFFF,1'b0,5'd0, 4'd6}, // R6 I blocks
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'hFFF,1'b1,5'd7, 4'd7}, // R7
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h002,1'b0,5'd0, 4'd7}, // R7 no enable
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h0A0,1'b1,5'd12,4'd7}, // R7
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h800,1'b1,5'd18,4'd8}, // R8 top rank
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,12'h800,1'b0,5'd0, 4'd7}, // R7 I blocks
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'hFFF,1'b1,5'd5, 4'd2}, // R2
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,12'h400,1'b1,5'd6, 4'd2}  // R2
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rst_ext_req, clkmon_fail, wdog_tmo, illegal_op, swi_req;
   logic          xirq_n, irq_n, ccr_x, ccr_i;
   logic [NP-1:0] periph_req;
   logic          cfg_we;
   logic [AW-1:0] cfg_addr;
   logic [DW-1:0] cfg_wdata;
   logic [DW-1:0] cfg_rdata;
   logic          req_valid;
   logic [SW-1:0] req_src;
   logic [15:0]   req_vector;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irq_arbiter u_irq_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .rst_ext_req (rst_ext_req),
      .clkmon_fail (clkmon_fail),
      .wdog_tmo    (wdog_tmo),
      .illegal_op  (illegal_op),
      .swi_req     (swi_req),
      .xirq_n      (xirq_n),
      .irq_n       (irq_n),
      .periph_req  (periph_req),
      .ccr_x       (ccr_x),
      .ccr_i       (ccr_i),
      .cfg_we      (cfg_we),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .req_valid   (req_valid),
      .req_src     (req_src),
      .req_vector  (req_vector)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rst_ext_req = 1'b0; clkmon_fail = 1'b0; wdog_tmo = 1'b0;
      illegal_op  = 1'b0; swi_req     = 1'b0;
      xirq_n = 1'b1; irq_n = 1'b1; ccr_x = 1'b0; ccr_i = 1'b0;
      periph_req = '0;
   endtask

   task automatic cfg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                               input string rq);
      cfg_addr = a;
      #1;
      chk(rq, "enable word readback", 32'(cfg_rdata), 32'(exp));
   endtask

   initial begin
      rst_n = 1'b0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      idle_inputs();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "valid in reset", 32'(req_valid), 32'd0);
      chk("R1", "src in reset", 32'(req_src), 32'd0);
      chk("R1", "vector in reset", 32'(req_vector), 32'd0);
      cfg_read_chk(2'd0, 8'h00, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset, idle", 32'(req_valid), 32'd0);

      // R11 enable words, pad bits and out-of-range address
      cfg_write(2'd0, 8'hA5);
      cfg_write(2'd1, 8'hFC);
      cfg_read_chk(2'd0, 8'hA5, "R11");
      cfg_read_chk(2'd1, 8'h0C, "R11");
      cfg_write(2'd2, 8'hFF);
      cfg_read_chk(2'd2, 8'h00, "R11");
      cfg_read_chk(2'd0, 8'hA5, "R11");
      cfg_read_chk(2'd1, 8'h0C, "R11");

      // table walk: R2..R9
      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         rst_ext_req = TBL[k].rst; clkmon_fail = TBL[k].cm; wdog_tmo = TBL[k].wd;
         illegal_op  = TBL[k].ill; swi_req     = TBL[k].swi;
         xirq_n = TBL[k].xn; irq_n = TBL[k].gn;
         ccr_x  = TBL[k].cx; ccr_i = TBL[k].ci;
         periph_req = TBL[k].pr;
         @(negedge clk);
         chk($sformatf("R%0d", TBL[k].rq), $sformatf("entry %0d valid", k),
             32'(req_valid), 32'(TBL[k].ev));
         chk($sformatf("R%0d", TBL[k].rq), $sformatf("entry %0d src", k),
             32'(req_src), 32'(TBL[k].es));
         chk("R8", $sformatf("entry %0d vector", k), 32'(req_vector),
             TBL[k].ev ? 32'(16'hFFFE - 16'(2 * TBL[k].es)) : 32'd0);
      end

      // R9 one-cycle latency, rise and fall
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      swi_req = 1'b1;
      #1;
      chk("R9", "valid before edge", 32'(req_valid), 32'd0);
      @(negedge clk);
      chk("R9", "valid after edge", 32'(req_valid), 32'd1);
      chk("R9", "src after edge", 32'(req_src), 32'd4);
      swi_req = 1'b0;
      #1;
      chk("R9", "valid held until edge", 32'(req_valid), 32'd1);
      @(negedge clk);
      chk("R9", "valid dropped", 32'(req_valid), 32'd0);

      // R10 held request offered again when mask clears
      irq_n = 1'b0; ccr_i = 1'b1;
      @(negedge clk);
      chk("R10", "masked request", 32'(req_valid), 32'd0);
      ccr_i = 1'b0;
      @(negedge clk);
      chk("R10", "valid after unmask", 32'(req_valid), 32'd1);
      chk("R10", "src after unmask", 32'(req_src), 32'd6);
      chk("R10", "vector after unmask", 32'(req_vector), 32'h0000FFF2);

      // R1 reset in the middle of activity
      rst_n = 1'b0;
      #1;
      chk("R1", "valid mid reset", 32'(req_valid), 32'd0);
      chk("R1", "src mid reset", 32'(req_src), 32'd0);
      cfg_read_chk(2'd0, 8'h00, "R1");
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule